// File: doc/BRIEF.md
# Transport-Triggered Move Processor Core

This block is a small processor core with one kind of instruction: a data move. Each instruction word holds one move slot per internal transport bus. A slot copies a value from a source to a destination. Work happens as a side effect of these moves. Writing a function unit's trigger port starts that unit, while writing one of its plain operand ports only stores the value. A result can be moved straight into another unit's port without passing through the register file.

The core fetches from its own instruction memory and talks to a separate data memory. Inside are an eight-entry register file, an ALU unit, a load/store unit and a jump unit. The hardware does no hazard checks. The program has to place every move in the cycle where its value is ready.

Top module: `tta_core`

## Requirements
- R1: While rst_n is low, imem_addr is 0 and dmem_we is 0. Reset clears the program counter, all registers, the ALU operand and result, the load result, the store data port and any pending jump.
- R2: The instruction word carries one 21-bit field per slot. Slot s sits at bits [21*s+20 : 21*s]. Inside a field, bit 20 is valid, [19:16] is the destination, [15:11] is the source, [10:8] is the ALU opcode and [7:0] is the immediate. Destinations: 0–7 are registers r0–r7, 8 is the ALU operand, 9 is the ALU trigger, 10 is the store data port, 11 is the load trigger (address), 12 is the store trigger (address) and 13 is the jump trigger. Sources: 0–7 are registers r0–r7, 8 is the ALU result, 9 is the load result and 31 is the sign-extended 8-bit immediate. Any other source reads as zero.
- R3: An ALU trigger computes operand OP trigger-value. The opcode values are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right and 7 signed set-less-than (result 1 or 0). If the operand port is written in the same word as the trigger, the ALU uses the value being written.
- R4: The ALU result can be read by the word after the trigger. It keeps that value until the next ALU trigger. A move from the ALU result to the ALU trigger reads the old result and reuses the stored operand.
- R5: After a load trigger word, the word right after it still reads the previous load result. The word after that reads the memory value at the triggered address. dmem_raddr shows that address from the cycle after the trigger.
- R6: A store trigger word causes exactly one cycle with dmem_we high, in the next cycle. In that cycle dmem_waddr is the trigger value and dmem_wdata is the store data port value. A data-port write in the same word is used. The data port keeps its value between stores.
- R7: A jump trigger sends the program to the target after one delay slot. The word after the jump word runs, and the word after that comes from the target address. Without a jump, the address goes up by one each cycle.
- R8: If two valid slots in one word name the same destination, the higher-numbered slot wins. A slot with valid 0 has no effect, and destinations 14 and 15 have no effect.
- R9: A register written by a word becomes readable in the next word. A read in the same word sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | PW | Address of the instruction word being executed |
| imem_data | input | NSLOT*21 | Instruction word at imem_addr, combinational read |
| dmem_raddr | output | AW | Data memory read address for the load in progress |
| dmem_rdata | input | DW | Data memory read data at dmem_raddr, combinational |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_waddr | output | AW | Data memory write address |
| dmem_wdata | output | DW | Data memory write data |

## Verification
The bench targets the cases a static schedule depends on.

- Operand and trigger, or data and store trigger, written in the same word. A core without the bypass would compute or store with the stale port value.
- A load result read one word too early. A core with the wrong latency would give back the memory word instead of the old result.
- A result moved from one unit straight into a trigger, and a register read and written in the same word. A wrong core here shows a new value where the old one was expected.
- Jump delay slots and same-destination collisions. A wrong core would run the skipped word, drop the delay slot, or let the lower slot win.
- Invalid slots and unused destinations. A core that is not careful here would emit stray stores or corrupt registers, and the scoreboard flags any store it did not expect.

// File: rtl/tta_pkg.sv
// Shared move-field layout, port identifiers and ALU opcodes for the move core.
package tta_pkg;
    localparam int IMM_W  = 8;
    localparam int DST_W  = 4;
    localparam int SRC_W  = 5;
    localparam int OPC_W  = 3;
    localparam int SLOT_W = 1 + DST_W + SRC_W + OPC_W + IMM_W;
    localparam int NDST   = 2 ** DST_W;
    localparam int NREG   = 8;
    localparam int RIDX_W = $clog2(NREG);

    typedef struct packed {
        logic             valid;
        logic [DST_W-1:0] dst;
        logic [SRC_W-1:0] src;
        logic [OPC_W-1:0] opc;
        logic [IMM_W-1:0] imm;
    } move_t;

    localparam logic [DST_W-1:0] D_ALU_OP   = 4'd8;
    localparam logic [DST_W-1:0] D_ALU_TRIG = 4'd9;
    localparam logic [DST_W-1:0] D_ST_DATA  = 4'd10;
    localparam logic [DST_W-1:0] D_LD_TRIG  = 4'd11;
    localparam logic [DST_W-1:0] D_ST_TRIG  = 4'd12;
    localparam logic [DST_W-1:0] D_JUMP     = 4'd13;

    localparam logic [SRC_W-1:0] S_ALU = 5'd8;
    localparam logic [SRC_W-1:0] S_LD  = 5'd9;
    localparam logic [SRC_W-1:0] S_IMM = 5'd31;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR, OP_SLT
    } alu_op_e;
endpackage

// File: rtl/tta_fetch.sv
// Program counter with a one-delay-slot jump.
// Assumes the instruction memory answers combinationally at the current address.
module tta_fetch #(
    parameter int DW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          jump_we,
    input  logic [DW-1:0] jump_wd,
    output logic [PW-1:0] pc
);
    logic [PW-1:0] pc_q;
    logic [PW-1:0] tgt_q;
    logic          pend_q;
    logic          unused_hi;

    assign unused_hi = ^jump_wd[DW-1:PW];
    assign pc        = pc_q;

    // Step the counter, or take a target registered one word earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            tgt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pc_q   <= pend_q ? tgt_q : pc_q + 1'b1;
            pend_q <= jump_we;
            if (jump_we) tgt_q <= jump_wd[PW-1:0];
        end
    end
endmodule

// File: rtl/tta_rf.sv
// Register file with one resolved write port per register; all registers readable.
// Assumes the caller has already settled collisions between slots.
module tta_rf #(
    parameter int DW   = 32,
    parameter int NREG = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREG-1:0]           we,
    input  logic [NREG-1:0][DW-1:0]   wd,
    output logic [NREG-1:0][DW-1:0]   q
);
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        // Hold or replace one register.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[r] <= '0;
            else if (we[r]) q[r] <= wd[r];
        end
    end
endmodule

// File: rtl/tta_alu_fu.sv
// ALU function unit: an operand port that only stores, and a trigger port that
// computes operand OP trigger-data into the result register (latency one).
// Assumes the operand written in the trigger's own word is forwarded.
module tta_alu_fu
    import tta_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_we,
    input  logic [DW-1:0] op_wd,
    input  logic          trig_we,
    input  logic [DW-1:0] trig_wd,
    input  alu_op_e       trig_opc,
    output logic [DW-1:0] res
);
    localparam int SH_W = $clog2(DW);

    logic [DW-1:0] opnd_q;
    logic [DW-1:0] opa;
    logic [DW-1:0] calc;

    // Compute the operation from the forwarded operand and the trigger data.
    always_comb begin
        opa = op_we ? op_wd : opnd_q;
        case (trig_opc)
            OP_ADD:  calc = opa + trig_wd;
            OP_SUB:  calc = opa - trig_wd;
            OP_AND:  calc = opa & trig_wd;
            OP_OR:   calc = opa | trig_wd;
            OP_XOR:  calc = opa ^ trig_wd;
            OP_SHL:  calc = opa << trig_wd[SH_W-1:0];
            OP_SHR:  calc = opa >> trig_wd[SH_W-1:0];
            default: calc = {{(DW-1){1'b0}}, $signed(opa) < $signed(trig_wd)};
        endcase
    end

    // Store the operand, and replace the result on a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opnd_q <= '0;
            res    <= '0;
        end else begin
            if (op_we)   opnd_q <= op_wd;
            if (trig_we) res    <= calc;
        end
    end
endmodule

// File: rtl/tta_lsu_fu.sv
// Load/store unit. A load trigger registers the address; the memory word is
// captured one cycle later. A store trigger drives one write cycle next cycle.
// Assumes the data memory reads combinationally.
module tta_lsu_fu #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sd_we,
    input  logic [DW-1:0] sd_wd,
    input  logic          ld_we,
    input  logic [DW-1:0] ld_wd,
    input  logic          st_we,
    input  logic [DW-1:0] st_wd,
    output logic [AW-1:0] dmem_raddr,
    input  logic [DW-1:0] dmem_rdata,
    output logic          dmem_we,
    output logic [AW-1:0] dmem_waddr,
    output logic [DW-1:0] dmem_wdata,
    output logic [DW-1:0] ld_res
);
    logic [DW-1:0] sd_q;
    logic          ld_pend_q;
    logic          unused_hi;

    assign unused_hi = ^{ld_wd[DW-1:AW], st_wd[DW-1:AW]};

    // Load pipeline, store register and store data port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_q       <= '0;
            ld_pend_q  <= 1'b0;
            dmem_raddr <= '0;
            ld_res     <= '0;
            dmem_we    <= 1'b0;
            dmem_waddr <= '0;
            dmem_wdata <= '0;
        end else begin
            if (sd_we) sd_q <= sd_wd;
            ld_pend_q <= ld_we;
            if (ld_we)     dmem_raddr <= ld_wd[AW-1:0];
            if (ld_pend_q) ld_res     <= dmem_rdata;
            dmem_we <= st_we;
            if (st_we) begin
                dmem_waddr <= st_wd[AW-1:0];
                dmem_wdata <= sd_we ? sd_wd : sd_q;
            end
        end
    end
endmodule

// File: rtl/tta_core.sv
// Move-only processor core. Each word holds NSLOT move slots that run in the
// same cycle. Sources are read, each destination takes the value from the
// highest valid slot naming it, and the units act on their trigger ports.
// Assumes a static schedule: there is no hazard detection.
module tta_core
    import tta_pkg::*;
#(
    parameter int DW    = 32,
    parameter int PW    = 8,
    parameter int AW    = 8,
    parameter int NSLOT = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [PW-1:0]           imem_addr,
    input  logic [NSLOT*SLOT_W-1:0] imem_data,
    output logic [AW-1:0]           dmem_raddr,
    input  logic [DW-1:0]           dmem_rdata,
    output logic                    dmem_we,
    output logic [AW-1:0]           dmem_waddr,
    output logic [DW-1:0]           dmem_wdata
);
    move_t                     mv      [NSLOT];
    logic [DW-1:0]             src_val [NSLOT];
    logic [NDST-1:0]           dwe;
    logic [NDST-1:0][DW-1:0]   dwd;
    alu_op_e                   alu_opc;
    logic [NREG-1:0][DW-1:0]   rf_q;
    logic [DW-1:0]             alu_res;
    logic [DW-1:0]             ld_res;
    logic                      jump_we;
    logic [DW-1:0]             jump_wd;
    logic                      alu_trig_we;
    logic                      ld_trig_we;
    logic [DW-1:0]             ld_trig_wd;
    logic                      st_trig_we;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign mv[s] = move_t'(imem_data[s*SLOT_W +: SLOT_W]);
        // Select the value this slot carries.
        always_comb begin
            if (mv[s].src < SRC_W'(NREG))
                src_val[s] = rf_q[mv[s].src[RIDX_W-1:0]];
            else if (mv[s].src == S_ALU)
                src_val[s] = alu_res;
            else if (mv[s].src == S_LD)
                src_val[s] = ld_res;
            else if (mv[s].src == S_IMM)
                src_val[s] = {{(DW-IMM_W){mv[s].imm[IMM_W-1]}}, mv[s].imm};
            else
                src_val[s] = '0;
        end
    end

    // Settle each destination; a later slot overrides an earlier one.
    always_comb begin
        dwe     = '0;
        dwd     = '0;
        alu_opc = OP_ADD;
        for (int s = 0; s < NSLOT; s++) begin
            if (mv[s].valid) begin
                dwe[mv[s].dst] = 1'b1;
                dwd[mv[s].dst] = src_val[s];
                if (mv[s].dst == D_ALU_TRIG) alu_opc = alu_op_e'(mv[s].opc);
            end
        end
    end

    assign jump_we     = dwe[D_JUMP];
    assign jump_wd     = dwd[D_JUMP];
    assign alu_trig_we = dwe[D_ALU_TRIG];
    assign ld_trig_we  = dwe[D_LD_TRIG];
    assign ld_trig_wd  = dwd[D_LD_TRIG];
    assign st_trig_we  = dwe[D_ST_TRIG];

    tta_fetch #(.DW(DW), .PW(PW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .jump_we(jump_we), .jump_wd(jump_wd), .pc(imem_addr)
    );

    tta_rf #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(dwe[NREG-1:0]), .wd(dwd[NREG-1:0]), .q(rf_q)
    );

    tta_alu_fu #(.DW(DW)) u_alu (
        .clk(clk), .rst_n(rst_n),
        .op_we(dwe[D_ALU_OP]), .op_wd(dwd[D_ALU_OP]),
        .trig_we(alu_trig_we), .trig_wd(dwd[D_ALU_TRIG]), .trig_opc(alu_opc),
        .res(alu_res)
    );

    tta_lsu_fu #(.DW(DW), .AW(AW)) u_lsu (
        .clk(clk), .rst_n(rst_n),
        .sd_we(dwe[D_ST_DATA]), .sd_wd(dwd[D_ST_DATA]),
        .ld_we(ld_trig_we), .ld_wd(ld_trig_wd),
        .st_we(st_trig_we), .st_wd(dwd[D_ST_TRIG]),
        .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata),
        .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
        .ld_res(ld_res)
    );
endmodule

// File: rtl/tta_core_chk.sv
// Timing checks for the move core: jump delay slot, unit latencies, result
// retention and store strobe. Bound into tta_core.
module tta_core_chk #(
    parameter int DW = 32,
    parameter int PW = 8,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [PW-1:0] imem_addr,
    input logic          jump_we,
    input logic [DW-1:0] jump_wd,
    input logic          alu_trig_we,
    input logic [DW-1:0] alu_res,
    input logic          ld_trig_we,
    input logic [DW-1:0] ld_trig_wd,
    input logic [DW-1:0] ld_res,
    input logic          st_trig_we,
    input logic          dmem_we,
    input logic [AW-1:0] dmem_raddr
);
    logic [1:0] cyc;

    // Count cycles since reset, saturating, to guard the history used below.
    always_ff @(posedge clk) begin
        if (!rst_n)           cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && $past(jump_we, 2)) |-> imem_addr == $past(jump_wd[PW-1:0], 2)); // R7
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && !$past(jump_we, 2)) |-> imem_addr == $past(imem_addr) + 1'b1); // R7
    AST_ALU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && !$past(alu_trig_we)) |-> $stable(alu_res)); // R4
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && !$past(ld_trig_we, 2)) |-> $stable(ld_res)); // R5
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1 && $past(ld_trig_we)) |-> dmem_raddr == $past(ld_trig_wd[AW-1:0])); // R5
    AST_STORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd1) |-> dmem_we == $past(st_trig_we)); // R6
endmodule

bind tta_core tta_core_chk #(.DW(DW), .PW(PW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
    .jump_we(jump_we), .jump_wd(jump_wd),
    .alu_trig_we(alu_trig_we), .alu_res(alu_res),
    .ld_trig_we(ld_trig_we), .ld_trig_wd(ld_trig_wd), .ld_res(ld_res),
    .st_trig_we(st_trig_we), .dmem_we(dmem_we), .dmem_raddr(dmem_raddr)
);

// File: tb/tta_core_tb.sv
// Scoreboard bench: the program builder pushes expected stores, the monitor
// pops and compares each data-memory write the core makes.
module tta_core_tb;
    localparam int DW = 32, PW = 8, AW = 8, NSLOT = 2, SW = 21;
    localparam int D_OP = 8, D_TRIG = 9, D_SD = 10, D_LD = 11, D_ST = 12, D_JMP = 13;
    localparam int S_ALU = 8, S_LD = 9, S_IMM = 31;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [PW-1:0]        imem_addr;
    logic [NSLOT*SW-1:0]  imem_data;
    logic [AW-1:0]        dmem_raddr, dmem_waddr;
    logic [DW-1:0]        dmem_rdata, dmem_wdata;
    logic                 dmem_we;

    logic [NSLOT*SW-1:0]  imem [256];
    logic [DW-1:0]        dmem [256];
    logic [AW+DW-1:0]     exp_q [$];
    string                tag_q [$];
    int                   checks = 0, errors = 0, widx = 0;
    bit                   done = 1'b0;

    always #5 clk = ~clk;

    tta_core #(.DW(DW), .PW(PW), .AW(AW), .NSLOT(NSLOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_raddr(dmem_raddr), .dmem_rdata(dmem_rdata), .dmem_we(dmem_we),
        .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata)
    );

    assign imem_data  = imem[imem_addr];
    assign dmem_rdata = dmem[dmem_raddr];

    always @(posedge clk) if (dmem_we) dmem[dmem_waddr] <= dmem_wdata;

    function automatic logic [SW-1:0] mf(int v, int d, int s, int o, int imm);
        logic [31:0] vv = v, dd = d, ss = s, oo = o, ii = imm;
        return {vv[0], dd[3:0], ss[4:0], oo[2:0], ii[7:0]};
    endfunction

    function automatic logic [SW-1:0] mi(int d, int imm, int o = 0);
        return mf(1, d, S_IMM, o, imm);
    endfunction

    function automatic logic [DW-1:0] alu_model(logic [DW-1:0] a, logic [DW-1:0] b, int op);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << b[4:0];
            6: return a >> b[4:0];
            default: return ($signed(a) < $signed(b)) ? 1 : 0;
        endcase
    endfunction

    task automatic emit(logic [SW-1:0] s0, logic [SW-1:0] s1);
        imem[widx] = {s1, s0};
        widx++;
    endtask

    task automatic expect_store(int addr, logic [DW-1:0] data, string tag);
        logic [31:0] a = addr;
        exp_q.push_back({a[AW-1:0], data});
        tag_q.push_back(tag);
    endtask

    task automatic store_reg(int r, int addr, logic [DW-1:0] data, string tag);
        emit(mf(1, D_SD, r, 0, 0), mi(D_ST, addr));
        expect_store(addr, data, tag);
    endtask

    // R3: both ALU ports written in one word, so the operand is forwarded.
    task automatic alu_case(int a, int b, int op, int addr);
        logic [31:0] av = a, bv = b;
        emit(mi(3, a), mi(4, b));
        emit(mf(1, D_OP, 3, 0, 0), mf(1, D_TRIG, 4, op, 0));
        emit(mf(1, D_SD, S_ALU, 0, 0), mi(D_ST, addr));
        expect_store(addr, alu_model(av, bv, op), $sformatf("R3 op%0d", op));
    endtask

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: every write strobe must match the head of the queue (R6).
    always @(negedge clk) begin
        if (rst_n && dmem_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected store", {dmem_waddr, dmem_wdata}, 0);
            end else begin
                logic [AW+DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({dmem_waddr, dmem_wdata} == e, t, {dmem_waddr, dmem_wdata}, e);
            end
        end
    end

    task automatic build_program();
        int j, e;
        for (int i = 0; i < 256; i++) begin
            imem[i] = '0;
            dmem[i] = DW'(i * 3);
        end
        dmem[5] = 32'h1234_5678;
        // R5 and R1: the early read sees the reset value 0, the later one the memory word.
        emit(mi(D_LD, 5), mf(0, 0, 0, 0, 0));
        emit(mf(1, 6, S_LD, 0, 0), mf(0, 0, 0, 0, 0));
        emit(mf(1, 7, S_LD, 0, 0), mf(0, 0, 0, 0, 0));
        store_reg(6, 100, 32'h0, "R5 early load read / R1 reset result");
        store_reg(7, 101, 32'h1234_5678, "R5 load result");
        // R2 sign extension, R3 all opcodes.
        alu_case(10, -3, 0, 0);
        alu_case(5, 9, 1, 1);
        alu_case(-16, 60, 2, 2);
        alu_case(33, 12, 3, 3);
        alu_case(85, 15, 4, 4);
        alu_case(3, 4, 5, 5);
        alu_case(-16, 2, 6, 6);
        alu_case(-2, 1, 7, 7);
        alu_case(5, -1, 7, 8);
        // R4: result into trigger reuses the stored operand and reads the old result.
        emit(mi(3, 7), mf(0, 0, 0, 0, 0));
        emit(mf(1, D_OP, 3, 0, 0), mi(D_TRIG, 6, 0));
        emit(mf(1, D_TRIG, S_ALU, 5, 0), mf(0, 0, 0, 0, 0));
        emit(mf(0, 0, 0, 0, 0), mf(0, 0, 0, 0, 0));
        emit(mf(1, D_SD, S_ALU, 0, 0), mi(D_ST, 20));
        expect_store(20, 32'h0000_E000, "R4 unit-to-unit and hold");
        // R9: a same-word read sees the old register value.
        emit(mi(1, 40), mf(0, 0, 0, 0, 0));
        emit(mf(1, 2, 1, 0, 0), mi(1, 50));
        store_reg(2, 30, 32'd40, "R9 old value read");
        store_reg(1, 31, 32'd50, "R9 new value");
        // R8: the higher slot wins; invalid slots and unused destinations do nothing.
        emit(mi(5, 1), mi(5, 2));
        emit(mf(0, 5, S_IMM, 0, 9), mi(14, 9));
        emit(mf(0, D_ST, S_IMM, 0, 70), mi(15, 9));
        store_reg(5, 40, 32'd2, "R8 slot priority / ignored moves");
        emit(mi(D_ST, 60), mi(D_ST, 61));
        expect_store(61, 32'd2, "R8 two store triggers / R6 data port held");
        // R7: jump with one delay slot; the word after the slot is skipped.
        j = widx;
        emit(mi(D_JMP, j + 3), mi(1, 11));
        emit(mi(2, 22), mf(0, 0, 0, 0, 0));
        emit(mi(1, 33), mi(2, 44));
        store_reg(1, 50, 32'd11, "R7 skipped word");
        store_reg(2, 51, 32'd22, "R7 delay slot");
        // End in a self-loop.
        e = widx;
        emit(mi(D_JMP, e), mf(0, 0, 0, 0, 0));
        emit(mf(0, 0, 0, 0, 0), mf(0, 0, 0, 0, 0));
    endtask

    initial begin
        build_program();
        repeat (3) @(negedge clk);
        check(imem_addr == 0, "R1 pc in reset", 64'(imem_addr), 0);
        check(dmem_we == 1'b0, "R1 no store in reset", 64'(dmem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(imem_addr == 1, "R7 pc steps after reset", 64'(imem_addr), 1);
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6 all expected stores seen", 64'(exp_q.size()), 0);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule